// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block resolves control flow for a 32-bit core with a single branch delay slot. For each accepted instruction it receives the instruction word, the address of that instruction and the two source register values. It registers the address to fetch after that instruction, a flag saying that the following instruction occupies a delay slot, and one-cycle pulses for delay-slot annulment, a return-address write to register 31, and an illegal control transfer.

It covers absolute jumps, jump-and-link, equal and not-equal compare branches and signed sign-test branches against zero, each in a plain and a likely form. When a jump or taken branch is accepted, the block holds the target internally. It returns `pc+4` so the slot instruction is fetched, then presents the held target once the slot instruction is accepted. Fetch, the register file and exception handling are outside the block.

Top module: `bnp_unit`

## Requirements
- R1: While `rst_ni` is low, `next_pc_o` is `RESET_PC` (default 0xBFC00000), and `delay_slot_o`, `annul_o`, `link_we_o` and `illegal_o` are 0.
- R2: An accepted instruction that is not a control transfer (opcode in bits 31:26 not 0x02-0x07 and not 0x14-0x17), outside a delay slot, sets `next_pc_o` to `pc_i+4` and leaves every flag at 0.
- R3: Opcode 0x02 (jump) sets `next_pc_o` to `pc_i+4` and raises `delay_slot_o`. The held target is `{pc_i[31:28], instr_i[25:0], 2'b00}`.
- R4: Opcode 0x03 (jump-and-link) behaves like R3 and also pulses `link_we_o` for one cycle, with `link_data_o = pc_i+8` as the value for register 31.
- R5: The target of a taken branch is `pc_i+4` plus `instr_i[15:0]` sign-extended and shifted left by 2.
- R6: The branch condition is selected by opcode bits 1:0. 00 is rs==rt, 01 is rs!=rt, 10 is signed rs<=0, and 11 is signed rs>0. Opcodes 0x04-0x07 are the plain forms.
- R7: A taken branch sets `next_pc_o` to `pc_i+4` and raises `delay_slot_o`. A plain branch that is not taken sets `next_pc_o` to `pc_i+4` with no flag raised.
- R8: Opcodes 0x14-0x17 are the likely forms of the R6 conditions. When taken they behave as in R7. When not taken they pulse `annul_o`, set `next_pc_o` to `pc_i+8` and leave `delay_slot_o` at 0.
- R9: The instruction accepted while `delay_slot_o` is 1 sets `next_pc_o` to the held target and clears `delay_slot_o`.
- R10: A jump or branch accepted while `delay_slot_o` is 1 pulses `illegal_o`. Its own redirect, link and annul are ignored, and R9 applies.
- R11: In a cycle without `valid_i`, `next_pc_o` and `delay_slot_o` hold their values, and `annul_o`, `link_we_o` and `illegal_o` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction accepted this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| next_pc_o | output | 32 | Address to fetch after the accepted instruction |
| delay_slot_o | output | 1 | Next instruction occupies a delay slot |
| annul_o | output | 1 | Delay slot cancelled by an untaken likely branch |
| link_we_o | output | 1 | Write return address to register 31 |
| link_data_o | output | 32 | Return address value |
| illegal_o | output | 1 | Control transfer found in a delay slot |

## Verification
The hardest situation to reach is a control transfer sitting in a delay slot. It requires a jump or taken branch immediately followed by a second one, and the second must carry a link or annul that has to be suppressed. The bench builds this by issuing a jump and then, at once, a taken branch or a jump-and-link. It checks that the first jump's target survives and that no link pulse appears. The sign tests are driven at rs values of 0, 1 and -1, and offsets 0x7FFF and 0x8000 exercise the displacement extremes.

// File: rtl/bnp_pkg.sv
package bnp_pkg;
  localparam int XLEN = 32;
  localparam int OPW  = 6;
  localparam int IDXW = 26;
  localparam int OFFW = 16;

  typedef enum logic [1:0] {
    COND_EQ  = 2'b00,
    COND_NE  = 2'b01,
    COND_LEZ = 2'b10,
    COND_GTZ = 2'b11
  } cond_e;

  typedef struct packed {
    logic            jump;
    logic            link;
    logic            branch;
    logic            likely;
    cond_e           cond;
    logic [IDXW-1:0] index;
    logic [OFFW-1:0] offset;
  } dec_t;
endpackage

// File: rtl/bnp_decode.sv
module bnp_decode
  import bnp_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [OPW-1:0] op;
  assign op = instr_i[XLEN-1 -: OPW];

  always_comb begin
    dec_o        = '0;
    dec_o.jump   = (op[OPW-1:1] == 5'b00001);
    dec_o.link   = (op == 6'h03);
    dec_o.branch = !op[5] && (op[3:2] == 2'b01);
    dec_o.likely = dec_o.branch && op[4];
    dec_o.cond   = cond_e'(op[1:0]);
    dec_o.index  = instr_i[IDXW-1:0];
    dec_o.offset = instr_i[OFFW-1:0];
  end
endmodule

// File: rtl/bnp_cond.sv
module bnp_cond
  import bnp_pkg::*;
(
  input  cond_e           cond_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            take_o
);
  logic eq, zero, neg;
  assign eq   = (rs_i == rt_i);
  assign zero = (rs_i == '0);
  assign neg  = rs_i[XLEN-1];

  always_comb begin
    unique case (cond_i)
      COND_EQ:  take_o = eq;
      COND_NE:  take_o = !eq;
      COND_LEZ: take_o = neg || zero;
      default:  take_o = !neg && !zero;
    endcase
  end
endmodule

// File: rtl/bnp_target.sv
module bnp_target
  import bnp_pkg::*;
(
  input  logic [XLEN-1:0] pc_i,
  input  logic [IDXW-1:0] index_i,
  input  logic [OFFW-1:0] offset_i,
  output logic [XLEN-1:0] seq4_o,
  output logic [XLEN-1:0] seq8_o,
  output logic [XLEN-1:0] jump_tgt_o,
  output logic [XLEN-1:0] br_tgt_o
);
  localparam int HIW = XLEN - IDXW - 2;
  localparam int SXW = XLEN - OFFW - 2;

  logic [XLEN-1:0] disp;
  assign disp       = {{SXW{offset_i[OFFW-1]}}, offset_i, 2'b00};
  assign seq4_o     = pc_i + XLEN'(4);
  assign seq8_o     = pc_i + XLEN'(8);
  assign jump_tgt_o = {pc_i[XLEN-1 -: HIW], index_i, 2'b00};
  assign br_tgt_o   = seq4_o + disp;
endmodule

// File: rtl/bnp_unit.sv
module bnp_unit
  import bnp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] next_pc_o,
  output logic        delay_slot_o,
  output logic        annul_o,
  output logic        link_we_o,
  output logic [31:0] link_data_o,
  output logic        illegal_o
);
  dec_t            dec;
  logic            take;
  logic [XLEN-1:0] seq4, seq8, jump_tgt, br_tgt;
  logic [XLEN-1:0] target_q;

  bnp_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  bnp_cond u_cond (
    .cond_i(dec.cond), .rs_i(rs_val_i), .rt_i(rt_val_i), .take_o(take)
  );

  bnp_target u_tgt (
    .pc_i(pc_i), .index_i(dec.index), .offset_i(dec.offset),
    .seq4_o(seq4), .seq8_o(seq8), .jump_tgt_o(jump_tgt), .br_tgt_o(br_tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o    <= RESET_PC;
      delay_slot_o <= 1'b0;
      annul_o      <= 1'b0;
      link_we_o    <= 1'b0;
      link_data_o  <= '0;
      illegal_o    <= 1'b0;
      target_q     <= '0;
    end else begin
      annul_o   <= 1'b0;
      link_we_o <= 1'b0;
      illegal_o <= 1'b0;
      if (valid_i) begin
        if (delay_slot_o) begin
          // slot: release held target, reject nested transfer
          next_pc_o    <= target_q;
          delay_slot_o <= 1'b0;
          illegal_o    <= dec.jump || dec.branch;
        end else if (dec.jump) begin
          next_pc_o    <= seq4;
          delay_slot_o <= 1'b1;
          target_q     <= jump_tgt;
          link_we_o    <= dec.link;
          link_data_o  <= seq8;
        end else if (dec.branch && take) begin
          next_pc_o    <= seq4;
          delay_slot_o <= 1'b1;
          target_q     <= br_tgt;
        end else if (dec.branch && dec.likely) begin
          next_pc_o <= seq8;
          annul_o   <= 1'b1;
        end else begin
          next_pc_o <= seq4;
        end
      end
    end
  end

  a_r8_annul_excl_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> !delay_slot_o);

  a_r4_link_has_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> delay_slot_o);

  a_r4_link_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_data_o == $past(pc_i) + 32'd8));

  a_r9_slot_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && delay_slot_o) |=> !delay_slot_o);

  a_r10_illegal_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($past(delay_slot_o) && !link_we_o && !annul_o));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(next_pc_o) && $stable(delay_slot_o) && !annul_o && !illegal_o));

  a_r1_pulses_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({annul_o, link_we_o, illegal_o}));
endmodule

// File: tb/bnp_unit_test.sv
module bnp_unit_test;
  localparam int PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'hBFC0_0000;
  localparam logic [31:0] NOP_I  = 32'h2401_0005;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0, pc = '0, rs = '0, rt = '0;
  logic [31:0] next_pc, link_data;
  logic        dslot, annul, link_we, illegal;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bnp_unit #(.RESET_PC(RST_PC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .pc_i(pc), .rs_val_i(rs), .rt_val_i(rt), .next_pc_o(next_pc),
    .delay_slot_o(dslot), .annul_o(annul), .link_we_o(link_we),
    .link_data_o(link_data), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; pc = p; rs = a; rt = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  function automatic logic [31:0] br_word(input logic [5:0] op, input logic [15:0] off);
    return {op, 5'd1, 5'd2, off};
  endfunction

  function automatic bit model_take(input logic [5:0] op, input logic [31:0] a,
                                    input logic [31:0] b);
    case (op[1:0])
      2'b00: return a == b;
      2'b01: return a != b;
      2'b10: return $signed(a) <= 0;
      default: return $signed(a) > 0;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 next_pc", next_pc, RST_PC);
    chk("R1 flags", {28'd0, dslot, annul, link_we, illegal}, 32'd0);
  endtask

  task automatic t_plain();
    issue(NOP_I, 32'h0000_0100, 0, 0);
    chk("R2 next_pc", next_pc, 32'h0000_0104);
    chk("R2 flags", {28'd0, dslot, annul, link_we, illegal}, 32'd0);
  endtask

  task automatic t_jump(input bit link, input logic [31:0] p, input logic [25:0] idx);
    logic [31:0] tgt;
    tgt = {p[31:28], idx, 2'b00};
    issue({5'b00001, link, idx}, p, 0, 0);
    chk("R3 jump next_pc", next_pc, p + 4);
    chk("R3 jump slot", {31'd0, dslot}, 32'd1);
    chk("R4 link pulse", {31'd0, link_we}, {31'd0, link});
    if (link) chk("R4 link data", link_data, p + 8);
    issue(NOP_I, p + 4, 0, 0);
    chk("R9 jump target", next_pc, tgt);
    chk("R9 slot cleared", {31'd0, dslot}, 32'd0);
  endtask

  task automatic t_branch(input logic [5:0] op, input logic [15:0] off,
                          input logic [31:0] p, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] tgt;
    bit tk;
    tk  = model_take(op, a, b);
    tgt = p + 4 + {{14{off[15]}}, off, 2'b00};
    issue(br_word(op, off), p, a, b);
    if (tk) begin
      chk("R7 taken next_pc", next_pc, p + 4);
      chk("R6 taken slot", {30'd0, dslot, annul}, 32'd2);
      issue(NOP_I, p + 4, 0, 0);
      chk("R5 branch target", next_pc, tgt);
    end else if (op[4]) begin
      chk("R8 annul next_pc", next_pc, p + 8);
      chk("R8 annul flags", {30'd0, dslot, annul}, 32'd1);
    end else begin
      chk("R7 not-taken next_pc", next_pc, p + 4);
      chk("R6 not-taken flags", {30'd0, dslot, annul}, 32'd0);
    end
  endtask

  task automatic t_illegal();
    issue({6'h02, 26'h0000040}, 32'h1000_0000, 0, 0);
    issue(br_word(6'h04, 16'h0010), 32'h1000_0004, 5, 5);
    chk("R10 illegal pulse", {31'd0, illegal}, 32'd1);
    chk("R10 target kept", next_pc, 32'h1000_0100);
    chk("R10 no slot", {30'd0, dslot, annul}, 32'd0);
    issue({6'h02, 26'h0000080}, 32'h1000_0100, 0, 0);
    issue({6'h03, 26'h0000001}, 32'h1000_0104, 0, 0);
    chk("R10 link ignored", {30'd0, link_we, illegal}, 32'd1);
    chk("R10 target kept jal", next_pc, 32'h1000_0200);
    issue(br_word(6'h14, 16'h0004), 32'h2000_0000, 1, 1);
    issue(br_word(6'h15, 16'h0004), 32'h2000_0004, 1, 1);
    chk("R10 annul ignored", {30'd0, annul, illegal}, 32'd1);
    chk("R10 likely target kept", next_pc, 32'h2000_0014);
  endtask

  task automatic t_idle();
    issue({6'h02, 26'h0000010}, 32'h0400_0000, 0, 0);
    repeat (3) @(negedge clk);
    chk("R11 hold next_pc", next_pc, 32'h0400_0004);
    chk("R11 hold slot", {28'd0, dslot, annul, link_we, illegal}, 32'd8);
    issue(NOP_I, 32'h0400_0004, 0, 0);
    chk("R11 resume target", next_pc, 32'h0000_0040);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_jump(1'b0, 32'hA000_0010, 26'h0123456);
    t_jump(1'b1, 32'h3000_0040, 26'h3FFFFFF);
    t_branch(6'h04, 16'h0010, 32'h0000_2000, 7, 7);
    t_branch(6'h04, 16'h0010, 32'h0000_2000, 7, 8);
    t_branch(6'h05, 16'hFFF0, 32'h0000_2000, 7, 8);
    t_branch(6'h05, 16'h0010, 32'h0000_2000, 9, 9);
    t_branch(6'h04, 16'h7FFF, 32'h0010_0000, 1, 1);
    t_branch(6'h04, 16'h8000, 32'h0010_0000, 1, 1);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] v;
      v = (k == 0) ? 32'd0 : (k == 1) ? 32'd1 : 32'hFFFF_FFFF;
      t_branch(6'h06, 16'h0020, 32'h0000_3000, v, 0);
      t_branch(6'h07, 16'h0020, 32'h0000_3000, v, 0);
      t_branch(6'h16, 16'hFFE0, 32'h0000_3000, v, 0);
      t_branch(6'h17, 16'hFFE0, 32'h0000_3000, v, 0);
    end
    t_branch(6'h14, 16'h0008, 32'h0000_4000, 3, 3);
    t_branch(6'h14, 16'h0008, 32'h0000_4000, 3, 4);
    t_branch(6'h15, 16'h0008, 32'h0000_4000, 3, 3);
    t_branch(6'h15, 16'h8000, 32'h0000_4000, 3, 4);
    t_illegal();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule